// File: doc/BRIEF.md
# Load Data Extract and Unpack

This block sits after the data-memory read port of a load pipeline. It turns a raw 64-bit little-endian read beat into the value a load writes back to the register file. The low bits of the access address pick the starting byte on the bus. A 4-bit operation code then selects the format:

- sign- or zero-extended byte and halfword loads;
- word and doubleword loads;
- byte-to-halfword lane unpacking, into a single register or a register pair;
- shift-in loads, which slide the previous 64-bit pair contents right and insert the new element at the top.

The caller presents one request per cycle with `rd_valid`, together with the current destination pair value (needed by the shift-in forms) and a cancel flag. The cancel flag comes from a predicate that evaluated false. The formatted result is registered. It appears one cycle later with `wb_valid` and a `wb_pair` flag that says whether the writeback covers a register pair or a single 32-bit register.

Control is a two-state machine.

- **S_IDLE**: no writeback is presented.
- **S_HOLD**: the registered result is presented.

Transitions:

- **T_ACCEPT** goes from either state to S_HOLD on a valid, uncancelled request with a legal code.
- **T_DRAIN** goes from either state to S_IDLE on any cycle without such a request.
- Reset forces S_IDLE.

Top module: `lde_top`

## Requirements
- R1: The selected data starts at bus byte `rd_offset` (byte k of the selection is `rd_data[8*(rd_offset+k)+:8]`). Positions past bus byte 7 read as zero.
- R2: Codes 0 (zero-extend) and 1 (sign-extend) take one byte to 32 bits. Bits 63:32 of the result are zero and `wb_pair` is 0.
- R3: Codes 2 (zero-extend) and 3 (sign-extend) take one halfword to 32 bits. Bits 63:32 are zero and `wb_pair` is 0.
- R4: Code 4 returns a 32-bit word with `wb_pair`=0. Code 5 returns all 64 bits with `wb_pair`=1.
- R5: Codes 6 (zero) and 7 (sign) place selected byte i, extended to 16 bits, in halfword lane i (bits 16i+15:16i) for i=0..1. Bits 63:32 are zero and `wb_pair`=0.
- R6: Codes 8 (zero) and 9 (sign) do the same for i=0..3 over the full 64 bits, with `wb_pair`=1.
- R7: Code 10 returns `{half, dst_old[63:16]}`, where half is the selected halfword, with `wb_pair`=1.
- R8: Code 11 returns `{byte, dst_old[63:8]}`, where byte is the selected byte, with `wb_pair`=1.
- R9: A request with `rd_valid`=1, `rd_cancel`=0 and a legal code (0..11) raises `wb_valid` in the following cycle, carrying that request's result.
- R10: A request with `rd_cancel`=1 produces no writeback: `wb_valid` is 0 in the following cycle.
- R11: Codes 12..15 are ignored: `wb_valid` is 0 in the following cycle.
- R12: Whenever `wb_valid` is 0, including during and right after reset, `wb_data` is zero and `wb_pair` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read beat and request present |
| rd_cancel | input | 1 | Predicate false: drop the writeback |
| rd_op | input | 4 | Format code (0..11 legal) |
| rd_offset | input | 3 | Low address bits: starting byte on the bus |
| rd_data | input | 64 | Raw little-endian read data |
| dst_old | input | 64 | Current destination pair value |
| wb_valid | output | 1 | Writeback present |
| wb_pair | output | 1 | Writeback covers a register pair |
| wb_data | output | 64 | Writeback value |

## Verification
The bench uses the default bus width of eight bytes. At that width the 3-bit offset spans every byte position. Halfword and multi-byte selections at high offsets therefore run off the top of the bus and expose the zero-fill of R1.

Random codes are drawn over the full 4-bit range, so illegal codes and cancels mix freely with back-to-back accepted requests. This covers every state transition, including S_HOLD to S_HOLD. Directed cases pin the sign boundaries 0x80 and 0x8000 and the shift-in insert positions.

// File: rtl/lde_pkg.sv
package lde_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_BYTE_U  = 4'd0,
        OP_BYTE_S  = 4'd1,
        OP_HALF_U  = 4'd2,
        OP_HALF_S  = 4'd3,
        OP_WORD    = 4'd4,
        OP_DWORD   = 4'd5,
        OP_UNP2_Z  = 4'd6,
        OP_UNP2_S  = 4'd7,
        OP_UNP4_Z  = 4'd8,
        OP_UNP4_S  = 4'd9,
        OP_SHIN_H  = 4'd10,
        OP_SHIN_B  = 4'd11
    } ld_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd11;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } wb_state_e;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return op <= OP_LAST;
    endfunction

endpackage

// File: rtl/lde_align.sv
// Slides the read beat down so that the addressed byte lands at byte 0.
module lde_align #(
    parameter int BUS_BYTES = 8
) (
    input  logic [BUS_BYTES*8-1:0]         data_in,
    input  logic [$clog2(BUS_BYTES)-1:0]   offset,
    output logic [BUS_BYTES*8-1:0]         data_out
);
    localparam int OFF_W = $clog2(BUS_BYTES);

    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_byte
        always_comb begin
            data_out[8*k +: 8] = 8'h00;
            for (int src = 0; src < BUS_BYTES; src++) begin
                if (src == k + int'(offset)) begin
                    data_out[8*k +: 8] = data_in[8*src +: 8];
                end
            end
        end
    end

    // OFF_W kept for readers sizing the offset port.
    logic [OFF_W-1:0] unused_off;
    assign unused_off = offset;

endmodule

// File: rtl/lde_format.sv
// Turns the aligned bytes into the writeback value for one format code.
module lde_format
    import lde_pkg::*;
#(
    parameter int RES_W = 64
) (
    input  logic [OP_W-1:0]  op,
    input  logic [RES_W-1:0] sel,
    input  logic [RES_W-1:0] old_val,
    output logic [RES_W-1:0] res,
    output logic             pair
);
    localparam int WORD_W = RES_W / 2;
    localparam int LANES  = RES_W / 16;

    logic [15:0] lane_z [LANES];
    logic [15:0] lane_s [LANES];
    logic [RES_W-1:0] unp_z;
    logic [RES_W-1:0] unp_s;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_z[i] = {8'h00, sel[8*i +: 8]};
        assign lane_s[i] = {{8{sel[8*i+7]}}, sel[8*i +: 8]};
        assign unp_z[16*i +: 16] = lane_z[i];
        assign unp_s[16*i +: 16] = lane_s[i];
    end

    always_comb begin
        res  = '0;
        pair = 1'b0;
        unique case (op)
            OP_BYTE_U: res[WORD_W-1:0] = {{(WORD_W-8){1'b0}}, sel[7:0]};
            OP_BYTE_S: res[WORD_W-1:0] = {{(WORD_W-8){sel[7]}}, sel[7:0]};
            OP_HALF_U: res[WORD_W-1:0] = {{(WORD_W-16){1'b0}}, sel[15:0]};
            OP_HALF_S: res[WORD_W-1:0] = {{(WORD_W-16){sel[15]}}, sel[15:0]};
            OP_WORD:   res[WORD_W-1:0] = sel[WORD_W-1:0];
            OP_DWORD: begin
                res  = sel;
                pair = 1'b1;
            end
            OP_UNP2_Z: res[WORD_W-1:0] = unp_z[WORD_W-1:0];
            OP_UNP2_S: res[WORD_W-1:0] = unp_s[WORD_W-1:0];
            OP_UNP4_Z: begin
                res  = unp_z;
                pair = 1'b1;
            end
            OP_UNP4_S: begin
                res  = unp_s;
                pair = 1'b1;
            end
            OP_SHIN_H: begin
                res  = {sel[15:0], old_val[RES_W-1:16]};
                pair = 1'b1;
            end
            OP_SHIN_B: begin
                res  = {sel[7:0], old_val[RES_W-1:8]};
                pair = 1'b1;
            end
            default: begin
                res  = '0;
                pair = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lde_top.sv
module lde_top
    import lde_pkg::*;
#(
    parameter int BUS_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_valid,
    input  logic                         rd_cancel,
    input  logic [3:0]                   rd_op,
    input  logic [$clog2(BUS_BYTES)-1:0] rd_offset,
    input  logic [BUS_BYTES*8-1:0]       rd_data,
    input  logic [BUS_BYTES*8-1:0]       dst_old,
    output logic                         wb_valid,
    output logic                         wb_pair,
    output logic [BUS_BYTES*8-1:0]       wb_data
);
    localparam int DW = BUS_BYTES * 8;

    wb_state_e      state_q, state_d;
    logic           accept;
    logic [DW-1:0]  aligned;
    logic [DW-1:0]  fmt_res;
    logic           fmt_pair;
    logic [DW-1:0]  res_q;
    logic           pair_q;

    lde_align #(.BUS_BYTES(BUS_BYTES)) u_align (
        .data_in  (rd_data),
        .offset   (rd_offset),
        .data_out (aligned)
    );

    lde_format #(.RES_W(DW)) u_format (
        .op      (rd_op),
        .sel     (aligned),
        .old_val (dst_old),
        .res     (fmt_res),
        .pair    (fmt_pair)
    );

    assign accept = rd_valid && !rd_cancel && op_legal(rd_op);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state: T_ACCEPT / T_DRAIN from either state
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE: state_d = accept ? S_HOLD : S_IDLE;
            S_HOLD: state_d = accept ? S_HOLD : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            pair_q <= 1'b0;
        end else if (accept) begin
            res_q  <= fmt_res;
            pair_q <= fmt_pair;
        end
    end

    // Outputs
    always_comb begin
        wb_valid = 1'b0;
        wb_pair  = 1'b0;
        wb_data  = '0;
        unique case (state_q)
            S_IDLE: ;
            S_HOLD: begin
                wb_valid = 1'b1;
                wb_pair  = pair_q;
                wb_data  = res_q;
            end
            default: ;
        endcase
    end

    AST_REQ_GIVES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_cancel && rd_op <= 4'd11) |=> wb_valid); // R9
    AST_WB_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(rd_valid)); // R9
    AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_cancel) |=> !wb_valid); // R10
    AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_op > 4'd11) |=> !wb_valid); // R11
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> (wb_data == '0 && !wb_pair)); // R12
    AST_SINGLE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_pair) |-> wb_data[DW-1:DW/2] == '0); // R2

endmodule

// File: tb/test_lde_top.sv
`timescale 1ns/1ps
module test_lde_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_valid, rd_cancel;
    logic [3:0]  rd_op;
    logic [2:0]  rd_offset;
    logic [63:0] rd_data, dst_old;
    logic        wb_valid, wb_pair;
    logic [63:0] wb_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic        exp_v;
    logic        exp_p;
    logic [63:0] exp_d;
    string       exp_tag;

    always #2.5 clk = ~clk;

    lde_top i_lde_top (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_cancel(rd_cancel),
        .rd_op(rd_op), .rd_offset(rd_offset), .rd_data(rd_data), .dst_old(dst_old),
        .wb_valid(wb_valid), .wb_pair(wb_pair), .wb_data(wb_data)
    );

    // Selection per R1: byte k = bus byte offset+k, zero past the top.
    function automatic logic [63:0] pick(input logic [63:0] d, input int off);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++)
            if (k + off < 8) r[8*k +: 8] = d[8*(k+off) +: 8];
        return r;
    endfunction

    function automatic logic [64:0] model(input logic [3:0] op, input int off,
                                          input logic [63:0] d, input logic [63:0] o);
        logic [63:0] s = pick(d, off);
        logic [63:0] r = '0;
        logic p = 1'b0;
        case (op)
            4'd0: r = {32'h0, 24'h0, s[7:0]};
            4'd1: r = {32'h0, {24{s[7]}}, s[7:0]};
            4'd2: r = {32'h0, 16'h0, s[15:0]};
            4'd3: r = {32'h0, {16{s[15]}}, s[15:0]};
            4'd4: r = {32'h0, s[31:0]};
            4'd5: begin r = s; p = 1; end
            4'd6: r = {32'h0, 8'h0, s[15:8], 8'h0, s[7:0]};
            4'd7: r = {32'h0, {8{s[15]}}, s[15:8], {8{s[7]}}, s[7:0]};
            4'd8: begin r = {8'h0, s[31:24], 8'h0, s[23:16], 8'h0, s[15:8], 8'h0, s[7:0]}; p = 1; end
            4'd9: begin r = {{8{s[31]}}, s[31:24], {8{s[23]}}, s[23:16],
                             {8{s[15]}}, s[15:8], {8{s[7]}}, s[7:0]}; p = 1; end
            4'd10: begin r = {s[15:0], o[63:16]}; p = 1; end
            4'd11: begin r = {s[7:0], o[63:8]}; p = 1; end
            default: r = '0;
        endcase
        return {p, r};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5: return "R4";
            4'd6, 4'd7: return "R5";
            4'd8, 4'd9: return "R6";
            4'd10:      return "R7";
            4'd11:      return "R8";
            default:    return "R11";
        endcase
    endfunction

    task automatic check_out();
        total++;
        if (wb_valid !== exp_v) begin
            bad++;
            $display("FAIL %s wb_valid act=%0b exp=%0b", exp_tag, wb_valid, exp_v);
        end else if (exp_v) begin
            if (wb_data !== exp_d || wb_pair !== exp_p) begin
                bad++;
                $display("FAIL %s data act=%h/%0b exp=%h/%0b", exp_tag, wb_data, wb_pair, exp_d, exp_p);
            end
        end else if (wb_data !== 64'h0 || wb_pair !== 1'b0) begin
            bad++;
            $display("FAIL R12 idle act=%h/%0b exp=0/0", wb_data, wb_pair);
        end
    endtask

    task automatic step(input logic v, input logic c, input logic [3:0] op,
                        input logic [2:0] off, input logic [63:0] d,
                        input logic [63:0] o, input string force_tag);
        logic [64:0] m;
        @(negedge clk);
        check_out();
        rd_valid = v; rd_cancel = c; rd_op = op; rd_offset = off;
        rd_data = d; dst_old = o;
        m = model(op, int'(off), d, o);
        exp_v = v && !c && (op <= 4'd11);
        exp_p = m[64];
        exp_d = m[63:0];
        if (force_tag != "")      exp_tag = force_tag;
        else if (!v)              exp_tag = "R12";
        else if (c)               exp_tag = "R10";
        else                      exp_tag = tag_of(op);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; rd_valid = 0; rd_cancel = 0; rd_op = 0; rd_offset = 0;
        rd_data = '0; dst_old = '0;
        exp_v = 0; exp_p = 0; exp_d = '0; exp_tag = "R12";
        repeat (3) @(negedge clk);
        check_out();   // R12 reset state
        rst_n = 1;

        // Directed corner cases
        step(1, 0, 4'd0, 3'd3, 64'h0000_0000_F000_0000, 64'h0, "R1");
        step(1, 0, 4'd1, 3'd0, 64'h0000_0000_0000_0080, 64'h0, "R2");
        step(1, 0, 4'd3, 3'd6, 64'h8001_0000_0000_0000, 64'h0, "R3");
        step(1, 0, 4'd2, 3'd7, 64'hAB00_0000_0000_0000, 64'h0, "R1");
        step(1, 0, 4'd5, 3'd0, 64'h0123_4567_89AB_CDEF, 64'h0, "R4");
        step(1, 0, 4'd4, 3'd4, 64'h8765_4321_0000_0000, 64'h0, "R4");
        step(1, 0, 4'd7, 3'd0, 64'h0000_0000_0000_807F, 64'h0, "R5");
        step(1, 0, 4'd9, 3'd4, 64'h80FF_017F_0000_0000, 64'h0, "R6");
        step(1, 0, 4'd8, 3'd5, 64'h80FF_017F_0000_0000, 64'h0, "R6");
        step(1, 0, 4'd10, 3'd2, 64'h0000_0000_BEEF_0000, 64'h1111_2222_3333_4444, "R7");
        step(1, 0, 4'd11, 3'd1, 64'h0000_0000_0000_5A00, 64'h1111_2222_3333_4444, "R8");
        step(1, 1, 4'd5, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R10");
        step(1, 0, 4'd13, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R11");
        step(0, 0, 4'd0, 3'd0, 64'h0, 64'h0, "R12");
        step(1, 0, 4'd0, 3'd0, 64'h0000_0000_0000_00C3, 64'h0, "R9");
        step(1, 0, 4'd1, 3'd1, 64'h0000_0000_0000_C300, 64'h0, "R9");

        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            logic v = ($urandom % 4) != 0;
            logic c = ($urandom % 8) == 0;
            logic [3:0] op = 4'($urandom % 16);
            logic [2:0] off = 3'($urandom % 8);
            logic [63:0] d = {$urandom, $urandom};
            logic [63:0] o = {$urandom, $urandom};
            step(v, c, op, off, d, o, "");
        end
        step(0, 0, 4'd0, 3'd0, 64'h0, 64'h0, "");
        @(negedge clk);
        check_out();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule